// File: doc/BRIEF.md
# SHA-256 Message Schedule Unit

This unit carries out the two message-expansion steps of SHA-256 on packed 128-bit operands holding four 32-bit words each. A two-bit opcode selects the step. The "prepare" step adds the small sigma0 of the following words to the four current words. The "finish" step produces four new schedule words W16..W19 with small sigma1. The finish step has a serial dependency inside the vector: its two upper result words are built from its two lower result words.

Software or a sequencer issues one operation per input beat. The lane-alignment add that joins the two steps, and all compression rounds, stay outside the unit. Both edges use valid/ready. An input beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. The result is registered and appears on the next cycle. A result is held until `out_valid` and `out_ready` are seen high together at an edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so with `out_ready` held high the unit accepts one operation per cycle.

Top module: `msg_sched_unit`

## Requirements
- R1: Opcode 2'b01 (prepare). Word lane i occupies bits [32i+31:32i]. Form vector V with V0=A1, V1=A2, V2=A3 and V3=B0. Result lane i is Ai + s0(Vi) modulo 2^32, where s0(x) = rotr(x,7) ^ rotr(x,18) ^ (x >> 3).
- R2: Opcode 2'b10 (finish). Let s1(x) = rotr(x,17) ^ rotr(x,19) ^ (x >> 10). The result lanes are L0 = A0+s1(B2), L1 = A1+s1(B3), L2 = A2+s1(L0) and L3 = A3+s1(L1), all modulo 2^32.
- R3: In the finish step, the upper result lanes use the lower result lanes computed in the same operation, not operand B. With A = {5,7,0,1} (lane 3 first) and B = 0, the result is {5,0000a007,0,1}.
- R4: Opcodes 2'b00 and 2'b11 are unknown. They return operand A unchanged, with `out_err` = 1 on that output beat only.
- R5: `out_err` is 0 for every beat produced by opcode 2'b01 or 2'b10.
- R6: `in_ready` is 0 exactly when `out_valid` is 1 and `out_ready` is 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_err` stay stable and `out_valid` stays 1.
- R8: Reset (`rst_n` low at a clock edge) clears `out_valid` and `out_err`.
- R9: A beat accepted at an edge is presented on `out_valid` right after that edge. With `out_ready` high, back-to-back beats produce one result per cycle, in order.
- R10: With both operands equal to 6f6d6521_61776573_20697320_52757374, the prepare step gives 2da4b536_77f29328_541a4d59_6afb680c. With A = 801a28aa_e75ff849_b591b2cc_8b64db2c and that value as B, the finish step gives e7c46c4e_8ce92ccc_d3c0f3ce_e9745c78.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_op | input | 2 | 01 prepare, 10 finish, other codes unknown |
| in_src_a | input | 128 | Operand A, lane 0 in bits 31:0 |
| in_src_b | input | 128 | Operand B, lane 0 in bits 31:0 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Result, lane 0 in bits 31:0 |
| out_err | output | 1 | Unknown opcode flag for this beat |

## Verification
The hardest behaviour to reach from the ports is the intra-vector dependency of the finish step. With typical operands, a wrong lane source still yields plausible-looking words. The stimulus therefore zeroes operand B, so that any use of B in the upper lanes adds nothing, and places a single set bit in A lane 0. The hand-derived value 0000a007 in lane 2 can then only come from s1 of the lane-0 result. A second difficult case is a stall that lasts while a new beat is already waiting. The bench holds `out_ready` low for several cycles with `in_valid` high, and checks that the held result and `in_ready` do not change before the queued beat moves through.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int HALF   = LANES / 2;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int OP_W   = 2;

  typedef enum logic [OP_W-1:0] {
    OP_PREP   = 2'b01,
    OP_FINISH = 2'b10
  } sched_op_e;

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] small_s0(input logic [WORD_W-1:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [WORD_W-1:0] small_s1(input logic [WORD_W-1:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/msg_sched_prep.sv
module msg_sched_prep
  import msg_sched_pkg::*;
(
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result
);
  // Shifted vector: lanes 0..LANES-2 take A lanes 1..LANES-1, top lane takes B lane 0
  logic [VEC_W-1:0] shifted;
  assign shifted = {src_b[WORD_W-1:0], src_a[VEC_W-1:WORD_W]};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign result[i*WORD_W +: WORD_W] =
      src_a[i*WORD_W +: WORD_W] + small_s0(shifted[i*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/msg_sched_finish.sv
module msg_sched_finish
  import msg_sched_pkg::*;
(
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result
);
  logic [WORD_W-1:0] lo_word [HALF];
  logic [WORD_W-1:0] hi_word [HALF];

  for (genvar i = 0; i < HALF; i++) begin : g_pair
    // lower half depends on operand B upper lanes
    assign lo_word[i] = src_a[i*WORD_W +: WORD_W]
                      + small_s1(src_b[(i+HALF)*WORD_W +: WORD_W]);
    // upper half chains on the lower half of this same operation
    assign hi_word[i] = src_a[(i+HALF)*WORD_W +: WORD_W] + small_s1(lo_word[i]);
    assign result[i*WORD_W +: WORD_W]        = lo_word[i];
    assign result[(i+HALF)*WORD_W +: WORD_W] = hi_word[i];
  end
endmodule

// File: rtl/msg_sched_out_stage.sv
module msg_sched_out_stage #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err
);
  logic take;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_err   <= in_err;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_err)); // R7
  AST_NO_TAKE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R6
  AST_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid); // R4
  AST_ACCEPT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !out_err); // R8
endmodule

// File: rtl/msg_sched_unit.sv
module msg_sched_unit
  import msg_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [VEC_W-1:0] in_src_a,
  input  logic [VEC_W-1:0] in_src_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  output logic             out_err
);
  logic [VEC_W-1:0] prep_res, fin_res, sel_res;
  logic             sel_err;

  msg_sched_prep u_prep (
    .src_a (in_src_a),
    .src_b (in_src_b),
    .result(prep_res)
  );

  msg_sched_finish u_finish (
    .src_a (in_src_a),
    .src_b (in_src_b),
    .result(fin_res)
  );

  always_comb begin
    sel_err = 1'b0;
    case (in_op)
      OP_PREP:   sel_res = prep_res;
      OP_FINISH: sel_res = fin_res;
      default: begin
        sel_res = in_src_a;
        sel_err = 1'b1;
      end
    endcase
  end

  msg_sched_out_stage #(.DATA_W(VEC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (sel_res),
    .in_err   (sel_err),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_err  (out_err)
  );

  AST_PASS_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 2'b00 || in_op == 2'b11)
    |=> out_err && out_data == $past(in_src_a)); // R4
  AST_ERR_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_op == 2'b01 || in_op == 2'b10) |=> !out_err); // R5
endmodule

// File: tb/msg_sched_unit_bench.sv
module msg_sched_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [1:0]   in_op;
  logic [127:0] in_src_a, in_src_b;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] out_data;
  logic         out_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msg_sched_unit u_msg_sched_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
  );

  // ---------------- reference from the requirements ----------------
  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction
  function automatic logic [31:0] ref_s0(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction
  function automatic logic [31:0] ref_s1(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction
  function automatic logic [127:0] ref_op(input logic [1:0] op, input logic [127:0] a, input logic [127:0] b);
    logic [31:0] al [4];
    logic [31:0] bl [4];
    logic [31:0] v  [4];
    logic [31:0] l  [4];
    for (int i = 0; i < 4; i++) begin
      al[i] = a[32*i +: 32];
      bl[i] = b[32*i +: 32];
    end
    if (op == 2'b01) begin
      v[0] = al[1]; v[1] = al[2]; v[2] = al[3]; v[3] = bl[0];
      for (int i = 0; i < 4; i++) l[i] = al[i] + ref_s0(v[i]);
    end else if (op == 2'b10) begin
      l[0] = al[0] + ref_s1(bl[2]);
      l[1] = al[1] + ref_s1(bl[3]);
      l[2] = al[2] + ref_s1(l[0]);
      l[3] = al[3] + ref_s1(l[1]);
    end else begin
      return a;
    end
    return {l[3], l[2], l[1], l[0]};
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask
  task automatic chk_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // one beat with the consumer ready; checks the beat right after acceptance
  task automatic run_op(input string tag, input logic [1:0] op, input logic [127:0] a,
                        input logic [127:0] b, input logic [127:0] exp, input logic exp_err);
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = op; in_src_a = a; in_src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit({tag, " R9 valid"}, out_valid, 1'b1);
    chk_vec({tag, " data"}, out_data, exp);
    chk_bit({tag, " err"}, out_err, exp_err);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_op = 2'b00; in_src_a = '0; in_src_b = '0;
    repeat (3) @(negedge clk);
    chk_bit("R8 reset out_valid", out_valid, 1'b0);
    chk_bit("R8 reset out_err", out_err, 1'b0);
    chk_bit("R6 ready when empty", in_ready, 1'b1);
    rst_n = 1'b1;
  endtask

  task automatic t_known_vectors;
    logic [127:0] w = 128'h6f6d6521_61776573_20697320_52757374;
    run_op("R10 prep vector", 2'b01, w, w, 128'h2da4b536_77f29328_541a4d59_6afb680c, 1'b0);
    run_op("R10 finish vector", 2'b10, 128'h801a28aa_e75ff849_b591b2cc_8b64db2c, w,
           128'he7c46c4e_8ce92ccc_d3c0f3ce_e9745c78, 1'b0);
    run_op("R2 finish chained", 2'b10, 128'h171911ae_e75ff849_b591b2cc_8b64db2c,
           128'he7c46c4e_8ce92ccc_d3c0f3ce_e9745c78,
           128'hc17c6ea3_c4d10083_712910cd_3f41c8ce, 1'b0);
  endtask

  task automatic t_prep_lanes;
    // r1_: A lane 1 = 8 feeds lane 0 via s0(8)=10020001
    run_op("R1 shift from A", 2'b01, 128'h00000000_00000000_00000008_00000000, '0,
           128'h00000000_00000000_00000008_10020001, 1'b0);
    // B lane 0 feeds the top lane
    run_op("R1 B lane0 to top", 2'b01, '0, 128'h00000000_00000000_00000000_00000008,
           128'h10020001_00000000_00000000_00000000, 1'b0);
    run_op("R1 mixed", 2'b01, 128'hdeadbeef_01234567_89abcdef_fedcba98,
           128'h0badf00d_11111111_22222222_33333333,
           ref_op(2'b01, 128'hdeadbeef_01234567_89abcdef_fedcba98,
                  128'h0badf00d_11111111_22222222_33333333), 1'b0);
  endtask

  task automatic t_finish_dependency;
    // R3: B = 0, lane 0 = 1 -> lane 2 gets 7 + s1(1) = 7 + a000
    run_op("R3 intra-vector", 2'b10, 128'h00000005_00000007_00000000_00000001, '0,
           128'h00000005_0000a007_00000000_00000001, 1'b0);
    run_op("R2 random", 2'b10, 128'h13579bdf_2468ace0_fedcba98_76543210,
           128'hcafebabe_8badf00d_55aa55aa_0f0f0f0f,
           ref_op(2'b10, 128'h13579bdf_2468ace0_fedcba98_76543210,
                  128'hcafebabe_8badf00d_55aa55aa_0f0f0f0f), 1'b0);
  endtask

  task automatic t_unknown_op;
    logic [127:0] a = 128'h01020304_05060708_090a0b0c_0d0e0f10;
    run_op("R4 op 00", 2'b00, a, 128'hffffffff_ffffffff_ffffffff_ffffffff, a, 1'b1);
    run_op("R4 op 11", 2'b11, a, '0, a, 1'b1);
    run_op("R5 err clears after unknown", 2'b01, a, '0, ref_op(2'b01, a, '0), 1'b0);
    @(negedge clk);
    chk_bit("R4 err only with beat", out_err, 1'b0);
  endtask

  task automatic t_backpressure;
    logic [127:0] a1 = 128'h11112222_33334444_55556666_77778888;
    logic [127:0] a2 = 128'h99990000_aaaabbbb_ccccdddd_eeeeffff;
    logic [127:0] e1 = ref_op(2'b10, a1, a2);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b10; in_src_a = a1; in_src_b = a2;
    @(negedge clk);
    in_op = 2'b00; in_src_a = a2; in_src_b = a1;
    for (int k = 0; k < 3; k++) begin
      chk_bit("R6 ready low in stall", in_ready, 1'b0);
      chk_bit("R7 valid held", out_valid, 1'b1);
      chk_vec("R7 data held", out_data, e1);
      chk_bit("R7 err held", out_err, 1'b0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    chk_bit("R6 ready on drain", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec("R9 queued beat after stall", out_data, a2);
    chk_bit("R4 queued unknown err", out_err, 1'b1);
    @(negedge clk);
    chk_bit("R9 drained", out_valid, 1'b0);
  endtask

  task automatic t_back_to_back;
    logic [127:0] a = 128'h0000ffff_ffff0000_12345678_9abcdef0;
    logic [127:0] b = 128'h87654321_0fedcba9_00000001_80000000;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid = 1'b1; in_op = 2'b01; in_src_a = a; in_src_b = b;
    @(negedge clk);
    chk_vec("R9 b2b first", out_data, ref_op(2'b01, a, b));
    in_op = 2'b10; in_src_a = b; in_src_b = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit("R9 b2b valid", out_valid, 1'b1);
    chk_vec("R9 b2b second", out_data, ref_op(2'b10, b, a));
    @(negedge clk);
    chk_bit("R9 b2b empty", out_valid, 1'b0);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b11; in_src_a = '1; in_src_b = '0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R8 reset drops valid", out_valid, 1'b0);
    chk_bit("R8 reset drops err", out_err, 1'b0);
    rst_n = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, MAX_CYCLES);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    t_reset();
    t_known_vectors();
    t_prep_lanes();
    t_finish_dependency();
    t_unknown_op();
    t_backpressure();
    t_back_to_back();
    t_reset_mid();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule